// File: doc/BRIEF.md
# Memory Array Integrity Signature Engine

This block walks every word of a chosen set of memory blocks, reads each word through a synchronous read port, and folds the read data into a 160-bit multiple-input signature register (MISR). Software loads a seed into five 32-bit signature words, picks blocks with two select masks, and chooses an address ordering. It then sets the enable bit and waits for the done flag. After that it reads the five words back and compares them against a signature it expects.

Two orderings are available. The linear ordering reads each block from its first word to its last. The diagnostic ordering reads each word and then the word at the bitwise-complement offset, so that every offset bit flips between the two reads of a pair. Both orderings read the same set of words. A protected region sits above the main blocks and is never addressed by a sweep. Clearing the enable bit before done stops the sweep at once and leaves a partial signature. While a sweep runs, read attempts from the system side are flagged.

Top module: `sig_sweep_engine`

## Requirements
- R1: After reset, every register reads 0, `mem_re` is 0 and `bus_rd_reject` is 0.
- R2: The register offsets are: 0 control (bit 0 enable, bit 1 ordering with 1 = linear and 0 = diagnostic, bit 2 done, read-only); 1 low-block mask; 2 high-block mask; 3 to 7 signature words 0 to 4. While enable is 1, writes to offsets 1 to 7 and to the ordering bit are ignored.
- R3: `mem_addr` is {block field [5:3], word offset [2:0]}. Low-mask bit i selects block i (0 to 3), and high-mask bit j selects block 4+j. Only selected blocks are read, and each of their words is read exactly once. Block field 6 is never issued.
- R4: In linear ordering, selected blocks are visited in ascending order and offsets run from 0 to 7.
- R5: In diagnostic ordering, selected blocks are visited in ascending order. Read number i within a block (i = 0 to 7, k = i/2) uses offset k when i is even and 7-k when i is odd. The set of words read equals the set read in linear ordering.
- R6: Signature word n holds bits 32n+31:32n. Each word returned one cycle after its address is folded as S' = (S<<1) ^ (S[159] ? P : 0) ^ {32'b0, data}, where P has bits 0, 2, 19 and 21 set. The signature does not change unless a word is folded or a signature word is written.
- R7: Writing 1 to the enable bit while it is 0 starts a sweep. Done rises once the last word has been folded, and no reads are issued while done is set. With both masks zero, done rises without any read and the signature equals the seed.
- R8: Writing 0 to the enable bit before done stops reads immediately. Done stays 0, the partial signature is held, and a re-seeded run afterwards gives the correct signature.
- R9: Writing 0 to the enable bit after done clears done.
- R10: When `bus_rd_req` is high during an active sweep, `bus_rd_reject` is 1 on the following cycle. It is 0 when the request is low or the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` of the previous cycle |
| bus_rd_req | input | 1 | System-side array read attempt |
| bus_rd_reject | output | 1 | Attempt refused because a sweep is active |
| mem_re | output | 1 | Array read enable |
| mem_addr | output | 6 | Array word address: block field and word offset |
| mem_rdata | input | 128 | Array read data, valid one cycle after the address |

## Verification
Four properties are checked on every cycle: the protected block field never appears on `mem_addr`; reads occur only while a sweep is busy and never while done is set or enable is clear; the signature holds still when nothing is folded or written; and a rejection always follows a request. The order in which words are visited, the set of words read under each ordering, the signature value itself, and the effects of abort and re-seeding cannot be expressed as single-cycle relations. These are shown only by the bench, which runs every mask combination under both orderings against an arithmetic model.

// File: rtl/sig_sweep_pkg.sv
package sig_sweep_pkg;
  // register offsets
  localparam int unsigned REG_CTRL     = 0;
  localparam int unsigned REG_MASK_LO  = 1;
  localparam int unsigned REG_MASK_HI  = 2;
  localparam int unsigned REG_SIG_BASE = 3;
  localparam int unsigned REG_WORD_W   = 32;

  // control bit positions
  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_SEQ  = 1;
  localparam int unsigned CB_DONE = 2;

  typedef enum logic {
    ORDER_DIAG   = 1'b0,
    ORDER_LINEAR = 1'b1
  } order_e;
endpackage

// File: rtl/sig_sweep_pick.sv
// Finds the lowest selected block whose index is at or above 'from'.
module sig_sweep_pick #(
  parameter int unsigned NBLK = 6,
  parameter int unsigned BLKW = 3
) (
  input  logic [NBLK-1:0] sel,
  input  logic [BLKW-1:0] from,
  output logic            found,
  output logic [BLKW-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int b = NBLK - 1; b >= 0; b--) begin
      if (sel[b] && (BLKW'(b) >= from)) begin
        found = 1'b1;
        pick  = BLKW'(b);
      end
    end
  end
endmodule

// File: rtl/sig_sweep_addr_gen.sv
// Address walker: block by block through the selection, with linear or
// complement-pair ordering inside each block.
module sig_sweep_addr_gen
  import sig_sweep_pkg::*;
#(
  parameter int unsigned NBLK = 6,
  parameter int unsigned BLKW = 3,
  parameter int unsigned BAW  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 stop,
  input  logic [NBLK-1:0]      sel,
  input  order_e               order,
  output logic                 valid,
  output logic                 last,
  output logic                 empty,
  output logic [BLKW+BAW-1:0]  addr
);
  logic [BLKW-1:0] blk_q;
  logic [BAW-1:0]  idx_q;
  logic [BAW-1:0]  offs;
  logic            first_found, next_found;
  logic [BLKW-1:0] first_blk, next_blk;
  logic [BLKW-1:0] blk_inc;
  logic            blk_end;

  assign blk_inc = blk_q + 1'b1;
  assign blk_end = &idx_q;

  sig_sweep_pick #(.NBLK(NBLK), .BLKW(BLKW)) u_first (
    .sel(sel), .from('0), .found(first_found), .pick(first_blk)
  );

  sig_sweep_pick #(.NBLK(NBLK), .BLKW(BLKW)) u_next (
    .sel(sel), .from(blk_inc), .found(next_found), .pick(next_blk)
  );

  generate
    if (BAW >= 2) begin : g_pair
      logic [BAW-2:0] half;
      assign half = idx_q[BAW-1:1];
      always_comb begin
        if (order == ORDER_LINEAR) offs = idx_q;
        else if (idx_q[0])         offs = ~{1'b0, half};
        else                       offs = {1'b0, half};
      end
    end else begin : g_single
      always_comb offs = (order == ORDER_LINEAR) ? idx_q : ~idx_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      blk_q <= '0;
      idx_q <= '0;
    end else if (stop) begin
      valid <= 1'b0;
    end else if (start) begin
      valid <= first_found;
      blk_q <= first_blk;
      idx_q <= '0;
    end else if (valid) begin
      if (blk_end) begin
        if (next_found) begin
          blk_q <= next_blk;
          idx_q <= '0;
        end else begin
          valid <= 1'b0;
        end
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign addr  = {blk_q, offs};
  assign last  = valid && blk_end && !next_found;
  assign empty = !first_found;
endmodule

// File: rtl/sig_sweep_misr.sv
// Multi-word signature register with per-word write port.
module sig_sweep_misr #(
  parameter int unsigned WORDS = 5,
  parameter int unsigned DW    = 128,
  parameter int unsigned TAP_A = 21,
  parameter int unsigned TAP_B = 19,
  parameter int unsigned TAP_C = 2,
  localparam int unsigned SIG_W = WORDS * 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [DW-1:0]    din,
  input  logic [WORDS-1:0] wr_word,
  input  logic [31:0]      wr_data,
  output logic [SIG_W-1:0] sig
);
  localparam logic [SIG_W-1:0] POLY = (SIG_W'(1) << TAP_A) | (SIG_W'(1) << TAP_B)
                                    | (SIG_W'(1) << TAP_C) | SIG_W'(1);

  logic [SIG_W-1:0] nxt;

  always_comb begin
    nxt = {sig[SIG_W-2:0], 1'b0} ^ SIG_W'(din);
    if (sig[SIG_W-1]) nxt = nxt ^ POLY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sig <= '0;
    end else if (cap) begin
      sig <= nxt;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (wr_word[w]) sig[w*32 +: 32] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/sig_sweep_engine.sv
module sig_sweep_engine
  import sig_sweep_pkg::*;
#(
  parameter int unsigned LO_BLOCKS  = 4,
  parameter int unsigned HI_BLOCKS  = 2,
  parameter int unsigned BLK_AW     = 3,
  parameter int unsigned DATA_W     = 128,
  parameter int unsigned SIG_WORDS  = 5,
  parameter int unsigned TAP_A      = 21,
  parameter int unsigned TAP_B      = 19,
  parameter int unsigned TAP_C      = 2,
  localparam int unsigned NBLK      = LO_BLOCKS + HI_BLOCKS,
  localparam int unsigned BLKW      = $clog2(NBLK + 1),
  localparam int unsigned ADDR_W    = BLKW + BLK_AW,
  localparam int unsigned SIG_W     = SIG_WORDS * 32,
  localparam int unsigned REG_AW    = $clog2(REG_SIG_BASE + SIG_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              bus_rd_req,
  output logic              bus_rd_reject,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(REG_CTRL);
  localparam logic [REG_AW-1:0] A_MLO  = REG_AW'(REG_MASK_LO);
  localparam logic [REG_AW-1:0] A_MHI  = REG_AW'(REG_MASK_HI);

  logic                 en_q, done_q, busy_q, rd_pend_q, last_pend_q;
  order_e               order_q;
  logic [LO_BLOCKS-1:0] mlo_q;
  logic [HI_BLOCKS-1:0] mhi_q;
  logic [SIG_W-1:0]     sig;
  logic [SIG_WORDS-1:0] sig_wr;
  logic [31:0]          rd_mux;
  logic                 ctrl_wr, start, stop, cap;
  logic                 gen_valid, gen_last, gen_empty;
  logic [ADDR_W-1:0]    gen_addr;

  assign ctrl_wr = reg_we && (reg_addr == A_CTRL);
  assign start   = ctrl_wr && reg_wdata[CB_EN] && !en_q;
  assign stop    = ctrl_wr && !reg_wdata[CB_EN] && en_q;
  assign cap     = rd_pend_q && !stop;

  sig_sweep_addr_gen #(.NBLK(NBLK), .BLKW(BLKW), .BAW(BLK_AW)) u_gen (
    .clk(clk), .rst(rst), .start(start), .stop(stop),
    .sel({mhi_q, mlo_q}), .order(order_q),
    .valid(gen_valid), .last(gen_last), .empty(gen_empty), .addr(gen_addr)
  );

  always_comb begin
    for (int w = 0; w < SIG_WORDS; w++) begin
      sig_wr[w] = reg_we && !en_q && (reg_addr == REG_AW'(REG_SIG_BASE + w));
    end
  end

  sig_sweep_misr #(
    .WORDS(SIG_WORDS), .DW(DATA_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .TAP_C(TAP_C)
  ) u_misr (
    .clk(clk), .rst(rst), .cap(cap), .din(mem_rdata),
    .wr_word(sig_wr), .wr_data(reg_wdata), .sig(sig)
  );

  assign mem_re   = gen_valid;
  assign mem_addr = gen_addr;

  // control, masks and sweep pipeline flags
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q          <= 1'b0;
      done_q        <= 1'b0;
      busy_q        <= 1'b0;
      rd_pend_q     <= 1'b0;
      last_pend_q   <= 1'b0;
      order_q       <= ORDER_DIAG;
      mlo_q         <= '0;
      mhi_q         <= '0;
      bus_rd_reject <= 1'b0;
    end else begin
      bus_rd_reject <= bus_rd_req && busy_q;
      rd_pend_q     <= gen_valid && !stop;
      last_pend_q   <= gen_last && !stop;

      if (ctrl_wr) begin
        en_q <= reg_wdata[CB_EN];
        if (!en_q) order_q <= order_e'(reg_wdata[CB_SEQ]);
      end

      if (stop) begin
        done_q <= 1'b0;
        busy_q <= 1'b0;
      end else if (start) begin
        busy_q <= !gen_empty;
        done_q <= gen_empty;
      end else if (rd_pend_q && last_pend_q) begin
        done_q <= 1'b1;
        busy_q <= 1'b0;
      end

      if (reg_we && !en_q && (reg_addr == A_MLO)) mlo_q <= reg_wdata[LO_BLOCKS-1:0];
      if (reg_we && !en_q && (reg_addr == A_MHI)) mhi_q <= reg_wdata[HI_BLOCKS-1:0];
    end
  end

  // registered read port
  always_comb begin
    rd_mux = '0;
    if (reg_addr == A_CTRL) begin
      rd_mux[CB_EN]   = en_q;
      rd_mux[CB_SEQ]  = order_q;
      rd_mux[CB_DONE] = done_q;
    end else if (reg_addr == A_MLO) begin
      rd_mux[LO_BLOCKS-1:0] = mlo_q;
    end else if (reg_addr == A_MHI) begin
      rd_mux[HI_BLOCKS-1:0] = mhi_q;
    end else begin
      for (int w = 0; w < SIG_WORDS; w++) begin
        if (reg_addr == REG_AW'(REG_SIG_BASE + w)) rd_mux = sig[w*32 +: 32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/sig_sweep_chk.sv
module sig_sweep_chk #(
  parameter int unsigned NBLK   = 6,
  parameter int unsigned BLKW   = 3,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned SIG_W  = 160
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              en,
  input logic              done,
  input logic              busy,
  input logic              rd_pend,
  input logic              reg_we,
  input logic [SIG_W-1:0]  sig,
  input logic              bus_rd_req,
  input logic              bus_rd_reject
);
  a_r3_no_shadow: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (mem_addr[ADDR_W-1 -: BLKW] < BLKW'(NBLK)));

  a_r7_reads_only_busy: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (busy && !done));

  a_r8_quiet_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !en |-> (!mem_re && !done));

  a_r6_sig_held: assert property (@(posedge clk) disable iff (rst)
    (!rd_pend && !reg_we) |=> $stable(sig));

  a_r10_reject_follows_req: assert property (@(posedge clk) disable iff (rst)
    bus_rd_reject |-> $past(bus_rd_req));

  a_r10_reject_when_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_rd_req) |=> bus_rd_reject);
endmodule

bind sig_sweep_engine sig_sweep_chk #(
  .NBLK(NBLK), .BLKW(BLKW), .ADDR_W(ADDR_W), .SIG_W(SIG_W)
) u_chk (
  .clk(clk), .rst(rst), .mem_re(mem_re), .mem_addr(mem_addr),
  .en(en_q), .done(done_q), .busy(busy_q), .rd_pend(rd_pend_q),
  .reg_we(reg_we), .sig(sig),
  .bus_rd_req(bus_rd_req), .bus_rd_reject(bus_rd_reject)
);

// File: tb/sim_sig_sweep_engine.sv
`timescale 1ns/1ps
module sim_sig_sweep_engine;
  localparam int NB = 6;
  localparam int W  = 8;
  localparam logic [159:0] POLY = 160'h1 | (160'h1 << 2) | (160'h1 << 19) | (160'h1 << 21);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         bus_rd_req = 1'b0;
  logic         bus_rd_reject;
  logic         mem_re;
  logic [5:0]   mem_addr;
  logic [127:0] mem_rdata = '0;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  sig_sweep_engine u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_rd_req(bus_rd_req), .bus_rd_reject(bus_rd_reject),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [127:0] word_of(int a);
    logic [31:0] x;
    x = 32'(a);
    return {x * 32'h9E3779B1, x * 32'h85EBCA6B + 32'd7, ~(x * 32'hC2B2AE35), x ^ 32'h3C3C0F0F};
  endfunction

  function automatic logic [159:0] fold(logic [159:0] s, logic [127:0] d);
    return {s[158:0], 1'b0} ^ (s[159] ? POLY : 160'h0) ^ {32'h0, d};
  endfunction

  // synchronous array model, one cycle of latency
  always @(posedge clk) if (mem_re) mem_rdata <= word_of(int'(mem_addr));

  int obs [64];
  int n_obs = 0;
  int bad_addr = 0;
  always @(negedge clk) begin
    if (mem_re) begin
      if (n_obs < 64) obs[n_obs] = int'(mem_addr);
      n_obs++;
      if (mem_addr[5:3] >= 3'd6) bad_addr++;
    end
  end

  int exp_list [64];
  int n_exp;

  task automatic build(input int m, input int lin);
    n_exp = 0;
    for (int b = 0; b < NB; b++) begin
      if (m[b]) begin
        for (int i = 0; i < W; i++) begin
          exp_list[n_exp] = b * W + ((lin != 0) ? i : ((i % 2 == 0) ? i / 2 : W - 1 - i / 2));
          n_exp++;
        end
      end
    end
  endtask

  task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic write_seed(input logic [159:0] s);
    for (int w = 0; w < 5; w++) reg_wr(3 + w, s[w*32 +: 32]);
  endtask

  task automatic read_sig(output logic [159:0] s);
    logic [31:0] d;
    for (int w = 0; w < 5; w++) begin
      reg_rd(3 + w, d);
      s[w*32 +: 32] = d;
    end
  endtask

  task automatic wait_done(output logic ok);
    logic [31:0] d;
    ok = 1'b0;
    for (int c = 0; c < 300; c++) begin
      reg_rd(0, d);
      if (d[2]) begin ok = 1'b1; break; end
    end
  endtask

  function automatic logic [159:0] model(logic [159:0] seed);
    logic [159:0] s;
    s = seed;
    for (int k = 0; k < n_exp; k++) s = fold(s, word_of(exp_list[k]));
    return s;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0]  d;
    logic [159:0] s, s2, seed;
    logic         ok;
    logic [47:0]  seen_lin, seen_diag, seen;
    int           errs;
    string        tag;

    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 mem_re after reset", 160'(mem_re), 0);
    chk("R1 reject after reset", 160'(bus_rd_reject), 0);
    for (int a = 0; a < 8; a++) begin
      reg_rd(a, d);
      chk("R1 register reset value", 160'(d), 0);
    end

    // every mask under both orderings (R3 R4 R5 R6 R7 R9)
    seen_lin = '0; seen_diag = '0;
    for (int m = 0; m < 64; m++) begin
      for (int lin = 0; lin < 2; lin++) begin
        seed = {32'(m * 7 + 1), 32'hC0DE0000 + 32'(m), 32'(lin) << 16, ~32'(m), 32'h0BADF00D};
        write_seed(seed);
        reg_wr(1, 32'(m % 16));
        reg_wr(2, 32'(m / 16));
        build(m, lin);
        n_obs = 0;
        reg_wr(0, 32'(lin * 2 + 1));
        wait_done(ok);
        chk("R7 done rises", 160'(ok), 1);
        @(negedge clk);
        chk("R7 no read while done", 160'(mem_re), 0);
        chk("R3 words read", 160'(n_obs), 160'(n_exp));
        errs = 0; seen = '0;
        for (int k = 0; k < n_obs && k < 64; k++) begin
          if (k >= n_exp || obs[k] != exp_list[k]) errs++;
          if (obs[k] < 48) seen[obs[k]] = 1'b1;
        end
        tag = (lin != 0) ? "R4 linear visit order" : "R5 diagnostic visit order";
        chk(tag, 160'(errs), 0);
        if (lin != 0) seen_lin = seen; else seen_diag = seen;
        read_sig(s2);
        chk((m == 0) ? "R7 empty selection keeps seed" : "R6 signature", s2, model(seed));
        reg_wr(0, 32'h0);
        reg_rd(0, d);
        chk("R9 done cleared with enable", 160'(d), 160'(lin * 2));
      end
      chk("R5 both orderings read same words", 160'(seen_diag), 160'(seen_lin));
    end

    // R2 configuration writes ignored while enabled
    seed = 160'h11112222_33334444_55556666_77778888_9999AAAA;
    write_seed(seed);
    reg_wr(1, 32'hF);
    reg_wr(2, 32'h3);
    reg_wr(0, 32'h3);
    reg_wr(1, 32'h0);
    reg_wr(3, 32'hFFFFFFFF);
    reg_wr(0, 32'h1);
    wait_done(ok);
    build(63, 1);
    read_sig(s2);
    chk("R2 signature unaffected by writes while enabled", s2, model(seed));
    reg_rd(1, d);
    chk("R2 mask kept while enabled", 160'(d), 160'hF);
    reg_rd(0, d);
    chk("R2 ordering bit kept while enabled", 160'(d), 160'h7);
    reg_wr(0, 32'h0);

    // R8 abort, with R10 checks while busy and while idle
    seed = 160'hDEADBEEF_01234567_89ABCDEF_FEDCBA98_76543210;
    write_seed(seed);
    reg_wr(0, 32'h1);
    repeat (6) @(negedge clk);
    bus_rd_req = 1'b1;
    @(negedge clk);
    chk("R10 reject during sweep", 160'(bus_rd_reject), 1);
    bus_rd_req = 1'b0;
    @(negedge clk);
    chk("R10 no reject without request", 160'(bus_rd_reject), 0);
    reg_wr(0, 32'h0);
    n_obs = 0;
    reg_rd(0, d);
    chk("R8 done low after abort", 160'(d), 0);
    read_sig(s);
    repeat (10) @(negedge clk);
    read_sig(s2);
    chk("R8 partial signature held", s2, s);
    chk("R8 reads stop on abort", 160'(n_obs), 0);
    bus_rd_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 no reject while idle", 160'(bus_rd_reject), 0);
    bus_rd_req = 1'b0;

    write_seed(seed);
    reg_wr(0, 32'h1);
    wait_done(ok);
    build(63, 0);
    read_sig(s2);
    chk("R8 reseeded run after abort", s2, model(seed));
    reg_wr(0, 32'h0);

    chk("R3 protected block never addressed", 160'(bad_addr), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule